// File: doc/BRIEF.md
# Single-step signed accumulator

This block keeps a running sum in a wide register and adds a narrow two's-complement term to it. The term is sign-extended to the width of the sum. The register is updated only when a small step controller gives a one-cycle enable. A person presses the arm button to apply the term presented on the inputs exactly once, then presses the re-arm button before the next addition. This makes it possible to follow the sum on a display one term at a time.

The register can be forced to zero with a synchronous clear. It can also be loaded with a parameterised preset value through a synchronous init input. Clear takes precedence over init, and init takes precedence over an addition. Overflow wraps modulo 2^SUM_W and raises no flag. The enable is a clock enable on the sum register: the whole block runs on one clock.

Top module: `step_accum`

## Requirements
- R1: While rst_ni is low, and after it is released, sum_o is zero and the controller is ready, so the first arm press produces an addition.
- R2: An addition sets sum_o to the old sum plus the term sign-extended from TERM_W to SUM_W bits (bit TERM_W-1 of term_i is the sign). From zero, adding 4'b1000 gives 8'hF8, and then adding 4'b1111 gives 8'hF7.
- R3: Holding arm_i high for any number of cycles in the ready state produces exactly one addition.
- R4: Once an addition has happened, arm_i has no effect until rearm_i has been sampled high. After that, arm_i produces an addition again.
- R5: rearm_i sampled in the ready state has no effect: sum_o does not change, and the next arm press still adds exactly once.
- R6: clear_i sampled high forces sum_o to zero at the next edge. This overrides init_i and a pending addition.
- R7: init_i sampled high with clear_i low loads INIT_VAL at the next edge. This overrides an addition due in the same cycle.
- R8: The sum wraps modulo 2^SUM_W. Nineteen additions of 7 from zero give 8'h85, and a further addition of -8 gives 8'h7D.
- R9: An addition takes effect on the second rising edge after arm_i is first sampled high. sum_o is unchanged after the first of those edges, and in every cycle with no addition, clear or init.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| term_i | input | TERM_W | Signed term to add |
| clear_i | input | 1 | Synchronous clear to zero |
| init_i | input | 1 | Synchronous load of INIT_VAL |
| arm_i | input | 1 | Requests one addition |
| rearm_i | input | 1 | Returns the controller to ready |
| sum_o | output | SUM_W | Running signed sum |

## Verification
An addition becomes visible on sum_o after the second rising edge that follows the first sampling of arm_i. Clear and init become visible one edge after they are sampled. The bench drives every input on a falling edge and samples sum_o on falling edges. For each step it checks that sum_o is still unchanged half a cycle after the first edge, and that it equals the bench's own wrapped sign-extended sum after the second. Arm presses that are held, repeated before a re-arm, or overlapped with init or clear are judged against the same schedule. The bench also samples again after the expected update to confirm that no second addition follows.

// File: rtl/step_accum_pkg.sv
`timescale 1ns/1ps
package step_accum_pkg;
  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_PULSE = 2'd1,
    ST_WAIT  = 2'd2
  } step_st_e;
endpackage

// File: rtl/step_ctrl.sv
`timescale 1ns/1ps
module step_ctrl
  import step_accum_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic rearm_i,
  output logic en_o
);
  step_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_READY: if (arm_i) st_d = ST_PULSE;
      ST_PULSE: st_d = ST_WAIT;
      ST_WAIT:  if (rearm_i) st_d = ST_READY;
      default:  st_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_READY;
    else         st_q <= st_d;
  end

  assign en_o = (st_q == ST_PULSE);

  // R3
  en_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> !en_o);

  // R3
  en_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> $past(arm_i));

  // R4
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !rearm_i) |=> !en_o);
endmodule

// File: rtl/sign_ext.sv
`timescale 1ns/1ps
module sign_ext #(
  parameter int TERM_W = 4,
  parameter int SUM_W  = 8
) (
  input  logic [TERM_W-1:0] term_i,
  output logic [SUM_W-1:0]  ext_o
);
  localparam int FILL_W = SUM_W - TERM_W + 1;

  for (genvar i = 0; i < SUM_W; i++) begin : g_bit
    if (i < TERM_W) begin : g_copy
      assign ext_o[i] = term_i[i];
    end else begin : g_fill
      assign ext_o[i] = term_i[TERM_W-1];
    end
  end

  // R2
  always_comb begin
    sext_fill_chk: assert (($countones(ext_o[SUM_W-1:TERM_W-1]) == 0) ||
                           ($countones(ext_o[SUM_W-1:TERM_W-1]) == FILL_W));
  end
endmodule

// File: rtl/acc_reg.sv
`timescale 1ns/1ps
module acc_reg #(
  parameter int              SUM_W    = 8,
  parameter logic [SUM_W-1:0] INIT_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             init_i,
  input  logic             en_i,
  input  logic [SUM_W-1:0] ext_i,
  output logic [SUM_W-1:0] sum_o
);
  logic [SUM_W-1:0] sum_q;

  // priority: clear, init, add; add wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sum_q <= '0;
    else if (clear_i) sum_q <= '0;
    else if (init_i)  sum_q <= INIT_VAL;
    else if (en_i)    sum_q <= sum_q + ext_i;
  end

  assign sum_o = sum_q;

  // R6
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (sum_q == '0));

  // R7
  init_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && !clear_i) |=> (sum_q == INIT_VAL));

  // R2
  add_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !init_i && !clear_i) |=> (sum_q == SUM_W'($past(sum_q) + $past(ext_i))));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !init_i && !clear_i) |=> $stable(sum_q));
endmodule

// File: rtl/step_accum.sv
`timescale 1ns/1ps
module step_accum #(
  parameter int               TERM_W   = 4,
  parameter int               SUM_W    = 8,
  parameter logic [SUM_W-1:0] INIT_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TERM_W-1:0] term_i,
  input  logic              clear_i,
  input  logic              init_i,
  input  logic              arm_i,
  input  logic              rearm_i,
  output logic [SUM_W-1:0]  sum_o
);
  logic             step_en;
  logic [SUM_W-1:0] term_ext;

  step_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm_i),
    .rearm_i (rearm_i),
    .en_o    (step_en)
  );

  sign_ext #(.TERM_W(TERM_W), .SUM_W(SUM_W)) u_sext (
    .term_i (term_i),
    .ext_o  (term_ext)
  );

  acc_reg #(.SUM_W(SUM_W), .INIT_VAL(INIT_VAL)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .init_i  (init_i),
    .en_i    (step_en),
    .ext_i   (term_ext),
    .sum_o   (sum_o)
  );
endmodule

// File: tb/tb_step_accum.sv
`timescale 1ns/1ps
module tb_step_accum;
  localparam logic [7:0] IV = 8'h25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] term = '0;
  logic       clr = 1'b0, ini = 1'b0, arm = 1'b0, rearm = 1'b0;
  logic [7:0] sum;
  logic [7:0] model = '0;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  step_accum #(.TERM_W(4), .SUM_W(8), .INIT_VAL(IV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .term_i(term), .clear_i(clr),
    .init_i(ini), .arm_i(arm), .rearm_i(rearm), .sum_o(sum)
  );

  function automatic logic [7:0] sx(input logic [3:0] t);
    return {{4{t[3]}}, t};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: sum=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_rearm();
    rearm = 1'b1; @(negedge clk); rearm = 1'b0; @(negedge clk);
  endtask

  task automatic do_step(input logic [3:0] t, input string tag);
    term = t; arm = 1'b1; @(negedge clk);
    arm = 1'b0;
    check({tag, " R9 hold"}, sum, model);
    @(negedge clk);
    model = model + sx(t);
    check(tag, sum, model);
    do_rearm();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 in reset", sum, 8'h00);
    rst_n = 1'b1; @(negedge clk);
    check("R1 after release", sum, 8'h00);
  endtask

  task automatic t_sext();
    do_step(4'b1000, "R2 add -8");
    check("R2 value F8", sum, 8'hF8);
    do_step(4'b1111, "R2 add -1");
    check("R2 value F7", sum, 8'hF7);
  endtask

  task automatic t_held_arm();
    term = 4'd3; arm = 1'b1;
    repeat (6) @(negedge clk);
    arm = 1'b0;
    model = model + 8'd3;
    check("R3 held arm one add", sum, model);
    @(negedge clk);
    check("R3 no second add", sum, model);
    do_rearm();
  endtask

  task automatic t_no_rearm();
    term = 4'd2; arm = 1'b1; @(negedge clk);
    arm = 1'b0; @(negedge clk);
    model = model + 8'd2;
    check("R4 first add", sum, model);
    term = 4'd5; arm = 1'b1;
    repeat (3) @(negedge clk);
    arm = 1'b0; @(negedge clk);
    check("R4 arm ignored before rearm", sum, model);
    do_rearm();
    do_step(4'd5, "R4 add after rearm");
  endtask

  task automatic t_idle_rearm();
    rearm = 1'b1;
    repeat (3) @(negedge clk);
    rearm = 1'b0; @(negedge clk);
    check("R5 rearm in ready no effect", sum, model);
    do_step(4'd1, "R5 single add");
  endtask

  task automatic t_clear();
    clr = 1'b1; @(negedge clk);
    clr = 1'b0; model = '0;
    check("R6 clear", sum, 8'h00);
    do_step(4'd4, "R6 add after clear");
    clr = 1'b1; ini = 1'b1; @(negedge clk);
    clr = 1'b0; ini = 1'b0; model = '0;
    check("R6 clear over init", sum, 8'h00);
    term = 4'd6; arm = 1'b1; @(negedge clk);
    arm = 1'b0; clr = 1'b1; @(negedge clk);
    clr = 1'b0;
    check("R6 clear over add", sum, 8'h00);
    @(negedge clk);
    check("R6 stays zero", sum, 8'h00);
    do_rearm();
  endtask

  task automatic t_init();
    ini = 1'b1; @(negedge clk);
    ini = 1'b0; model = IV;
    check("R7 init load", sum, IV);
    do_step(4'd2, "R7 add after init");
    term = 4'd6; arm = 1'b1; @(negedge clk);
    arm = 1'b0; ini = 1'b1; @(negedge clk);
    ini = 1'b0; model = IV;
    check("R7 init over add", sum, IV);
    @(negedge clk);
    check("R7 no late add", sum, IV);
    do_rearm();
  endtask

  task automatic t_wrap();
    clr = 1'b1; @(negedge clk);
    clr = 1'b0; model = '0;
    for (int i = 0; i < 19; i++) do_step(4'd7, "R8 add 7");
    check("R8 wrapped 85", sum, 8'h85);
    do_step(4'b1000, "R8 add -8");
    check("R8 value 7D", sum, 8'h7D);
  endtask

  initial begin
    t_reset();
    t_sext();
    t_held_arm();
    t_no_rearm();
    t_idle_rearm();
    t_clear();
    t_init();
    t_wrap();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule